// File: doc/BRIEF.md
# Masked Lane Move and Select Unit

This execution unit performs the mask-driven data-movement operations of a 32-lane vector engine. Per-lane branching is not available, so lanes are steered by a lane mask. The unit carries out three operations. A masked move writes a source into the enabled lanes and keeps the old contents elsewhere. A per-lane select chooses between two operands. A first-true extraction returns the value of the lowest enabled lane as a scalar.

The lane mask comes from a compact 12-bit mask operand. The operand names two mask registers, and each reference can be inverted. The unit drives the two register indices to the register file. It gets back the two register contents. In each lane it inverts each bit as the operand asks and ANDs the two bits together. Each value operand is either a full vector or a scalar broadcast to every lane. The scalar is an immediate or element 0 of a vector register. The result vector, the per-lane write enables, the scalar result and its write enable are registered once, so results appear one cycle after issue.

Top module: `mask_lane_unit`

## Requirements
- R1: The mask operand fields are: bits [4:0] index A, bit [5] invert A, bits [10:6] index B, bit [11] invert B. `mask_a_idx_o` and `mask_b_idx_o` present the two indices combinationally.
- R2: The mask bit of lane i is (bit 0 of element i of register A XOR invert A) AND (bit 0 of element i of register B XOR invert B). Element i occupies bits [32*i+31:32*i] of a vector.
- R3: Move (op 2'b00) outputs operand A in lanes whose mask bit is 1 and `dst_old_i` in the other lanes. `vec_we_o` equals the lane mask.
- R4: Select (op 2'b01) outputs operand B in lanes whose mask bit is 1 and operand A in the other lanes. All 32 bits of `vec_we_o` are set.
- R5: First-true (op 2'b10) with at least one mask bit set loads operand A's value from the lowest-numbered enabled lane into `scalar_o` and raises `scalar_we_o`.
- R6: First-true with an all-zero mask leaves `scalar_we_o` low and `scalar_o` unchanged.
- R7: An operand kind of 2'b00 passes the vector. 2'b01 broadcasts the immediate. 2'b10 and 2'b11 broadcast element 0 of the vector.
- R8: Results and `valid_o` appear on the clock edge after `valid_i` is sampled high. A cycle without `valid_i` gives all write enables low in the next cycle.
- R9: After reset all outputs are zero.
- R10: Op 2'b11 is reserved and raises no write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Issue strobe |
| op_i | input | 2 | Operation code |
| mask_op_i | input | 12 | Compact mask operand |
| mask_a_idx_o | output | 5 | Register index for mask A |
| mask_b_idx_o | output | 5 | Register index for mask B |
| mask_a_data_i | input | 1024 | Contents of mask register A |
| mask_b_data_i | input | 1024 | Contents of mask register B |
| src_a_kind_i | input | 2 | Kind of operand A |
| src_a_vec_i | input | 1024 | Vector for operand A |
| src_a_imm_i | input | 32 | Immediate for operand A |
| src_b_kind_i | input | 2 | Kind of operand B |
| src_b_vec_i | input | 1024 | Vector for operand B |
| src_b_imm_i | input | 32 | Immediate for operand B |
| dst_old_i | input | 1024 | Previous destination contents |
| valid_o | output | 1 | Result valid |
| vec_o | output | 1024 | Result vector |
| vec_we_o | output | 32 | Per-lane write enables |
| scalar_o | output | 32 | Scalar result |
| scalar_we_o | output | 1 | Scalar write enable |

## Verification
The bench builds the unit with its default 32 lanes, 32-bit elements and 5-bit register indices. At this size the highest lane and the invert bits can be reached. Register 0 of the modelled register file is held at all zeros, so the bench can produce an all-ones mask (both references inverted) and an empty mask (one register ANDed with its own inverse). Random operands with mixed operand kinds cover the broadcast paths.

// File: rtl/mlu_pkg.sv
package mlu_pkg;
  typedef enum logic [1:0] {
    OP_MOV = 2'b00,
    OP_SEL = 2'b01,
    OP_FWT = 2'b10,
    OP_RSV = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    KIND_VEC = 2'b00,
    KIND_IMM = 2'b01,
    KIND_EL0 = 2'b10,
    KIND_EL1 = 2'b11
  } kind_e;
endpackage

// File: rtl/mask_decode.sv
module mask_decode #(
  parameter int LANES = 32,
  parameter int DW    = 32,
  parameter int IDX_W = 5,
  localparam int FLD_W = IDX_W + 1,
  localparam int OPW   = 2 * FLD_W
) (
  input  logic [OPW-1:0]        mask_op_i,
  output logic [IDX_W-1:0]      idx_a_o,
  output logic [IDX_W-1:0]      idx_b_o,
  input  logic [LANES*DW-1:0]   reg_a_i,
  input  logic [LANES*DW-1:0]   reg_b_i,
  output logic [LANES-1:0]      lane_mask_o
);
  logic inv_a, inv_b;

  assign idx_a_o = mask_op_i[IDX_W-1:0];
  assign inv_a   = mask_op_i[IDX_W];
  assign idx_b_o = mask_op_i[FLD_W+IDX_W-1:FLD_W];
  assign inv_b   = mask_op_i[FLD_W+IDX_W];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic bit_a, bit_b;
    assign bit_a = reg_a_i[l*DW] ^ inv_a;
    assign bit_b = reg_b_i[l*DW] ^ inv_b;
    assign lane_mask_o[l] = bit_a & bit_b;
  end
endmodule

// File: rtl/dist_bcast.sv
module dist_bcast #(
  parameter int LANES = 32,
  parameter int DW    = 32
) (
  input  logic [1:0]          kind_i,
  input  logic [LANES*DW-1:0] vec_i,
  input  logic [DW-1:0]       imm_i,
  output logic [LANES*DW-1:0] vec_o
);
  import mlu_pkg::*;
  logic [DW-1:0] scalar;

  always_comb begin
    unique case (kind_e'(kind_i))
      KIND_IMM: scalar = imm_i;
      default:  scalar = vec_i[DW-1:0];
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign vec_o[l*DW +: DW] = (kind_e'(kind_i) == KIND_VEC) ? vec_i[l*DW +: DW] : scalar;
  end
endmodule

// File: rtl/first_pick.sv
module first_pick #(
  parameter int LANES = 32,
  parameter int DW    = 32
) (
  input  logic [LANES-1:0]    mask_i,
  input  logic [LANES*DW-1:0] vals_i,
  output logic                found_o,
  output logic [DW-1:0]       value_o
);
  logic [LANES-1:0] lowest;

  // isolate lowest set bit
  assign lowest  = mask_i & (~mask_i + LANES'(1));
  assign found_o = |mask_i;

  always_comb begin
    value_o = '0;
    for (int l = 0; l < LANES; l++) begin
      value_o |= {DW{lowest[l]}} & vals_i[l*DW +: DW];
    end
  end
endmodule

// File: rtl/mask_lane_unit.sv
module mask_lane_unit #(
  parameter int LANES = 32,
  parameter int DW    = 32,
  parameter int IDX_W = 5,
  localparam int OPW  = 2 * (IDX_W + 1),
  localparam int VW   = LANES * DW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       op_i,
  input  logic [OPW-1:0]   mask_op_i,
  output logic [IDX_W-1:0] mask_a_idx_o,
  output logic [IDX_W-1:0] mask_b_idx_o,
  input  logic [VW-1:0]    mask_a_data_i,
  input  logic [VW-1:0]    mask_b_data_i,
  input  logic [1:0]       src_a_kind_i,
  input  logic [VW-1:0]    src_a_vec_i,
  input  logic [DW-1:0]    src_a_imm_i,
  input  logic [1:0]       src_b_kind_i,
  input  logic [VW-1:0]    src_b_vec_i,
  input  logic [DW-1:0]    src_b_imm_i,
  input  logic [VW-1:0]    dst_old_i,
  output logic             valid_o,
  output logic [VW-1:0]    vec_o,
  output logic [LANES-1:0] vec_we_o,
  output logic [DW-1:0]    scalar_o,
  output logic             scalar_we_o
);
  import mlu_pkg::*;

  logic [LANES-1:0] lane_mask;
  logic [VW-1:0]    opnd_a, opnd_b;
  logic             pick_found;
  logic [DW-1:0]    pick_val;
  logic [VW-1:0]    vec_d;
  logic [LANES-1:0] we_d;
  logic             swe_d;
  op_e              op;

  assign op = op_e'(op_i);

  mask_decode #(.LANES(LANES), .DW(DW), .IDX_W(IDX_W)) u_mdec (
    .mask_op_i  (mask_op_i),
    .idx_a_o    (mask_a_idx_o),
    .idx_b_o    (mask_b_idx_o),
    .reg_a_i    (mask_a_data_i),
    .reg_b_i    (mask_b_data_i),
    .lane_mask_o(lane_mask)
  );

  dist_bcast #(.LANES(LANES), .DW(DW)) u_dist_a (
    .kind_i(src_a_kind_i), .vec_i(src_a_vec_i), .imm_i(src_a_imm_i), .vec_o(opnd_a)
  );

  dist_bcast #(.LANES(LANES), .DW(DW)) u_dist_b (
    .kind_i(src_b_kind_i), .vec_i(src_b_vec_i), .imm_i(src_b_imm_i), .vec_o(opnd_b)
  );

  first_pick #(.LANES(LANES), .DW(DW)) u_pick (
    .mask_i(lane_mask), .vals_i(opnd_a), .found_o(pick_found), .value_o(pick_val)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      unique case (op)
        OP_MOV:  vec_d[l*DW +: DW] = lane_mask[l] ? opnd_a[l*DW +: DW] : dst_old_i[l*DW +: DW];
        OP_SEL:  vec_d[l*DW +: DW] = lane_mask[l] ? opnd_b[l*DW +: DW] : opnd_a[l*DW +: DW];
        default: vec_d[l*DW +: DW] = '0;
      endcase
    end
  end

  always_comb begin
    we_d  = '0;
    swe_d = 1'b0;
    if (valid_i) begin
      unique case (op)
        OP_MOV:  we_d  = lane_mask;
        OP_SEL:  we_d  = '1;
        OP_FWT:  swe_d = pick_found;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      vec_o       <= '0;
      vec_we_o    <= '0;
      scalar_o    <= '0;
      scalar_we_o <= 1'b0;
    end else begin
      valid_o     <= valid_i;
      vec_we_o    <= we_d;
      scalar_we_o <= swe_d;
      if (valid_i) vec_o <= vec_d;
      if (swe_d)   scalar_o <= pick_val;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R8
  AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (vec_we_o == '0 && !scalar_we_o)); // R8
  AST_MOV_WE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == OP_MOV) |=> vec_we_o == $past(lane_mask)); // R3
  AST_SEL_ALL_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == OP_SEL) |=> (&vec_we_o)); // R4
  AST_FWT_NONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == OP_FWT && lane_mask == '0) |=> (!scalar_we_o && $stable(scalar_o))); // R6
  AST_SCALAR_ONLY_FWT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scalar_we_o |-> $past(valid_i && op == OP_FWT)); // R5
  AST_RSV_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == OP_RSV) |=> (vec_we_o == '0 && !scalar_we_o)); // R10
endmodule

// File: tb/tb_mask_lane_unit.sv
module tb_mask_lane_unit;
  localparam int LANES = 32;
  localparam int DW = 32;
  localparam int IDX_W = 5;
  localparam int VW = LANES * DW;
  localparam int CLK_PERIOD = 10;
  localparam int SEED = 1234;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [1:0] op_i = '0;
  logic [11:0] mask_op_i = '0;
  logic [IDX_W-1:0] mask_a_idx_o, mask_b_idx_o;
  logic [VW-1:0] mask_a_data_i, mask_b_data_i;
  logic [1:0] src_a_kind_i = '0, src_b_kind_i = '0;
  logic [VW-1:0] src_a_vec_i = '0, src_b_vec_i = '0, dst_old_i = '0;
  logic [DW-1:0] src_a_imm_i = '0, src_b_imm_i = '0;
  logic valid_o, scalar_we_o;
  logic [VW-1:0] vec_o;
  logic [LANES-1:0] vec_we_o;
  logic [DW-1:0] scalar_o;

  logic [LANES-1:0] rf_bits [32];
  int checks = 0, fails = 0;
  logic [DW-1:0] exp_scalar = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mask_lane_unit #(.LANES(LANES), .DW(DW), .IDX_W(IDX_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .mask_op_i(mask_op_i),
    .mask_a_idx_o(mask_a_idx_o), .mask_b_idx_o(mask_b_idx_o),
    .mask_a_data_i(mask_a_data_i), .mask_b_data_i(mask_b_data_i),
    .src_a_kind_i(src_a_kind_i), .src_a_vec_i(src_a_vec_i), .src_a_imm_i(src_a_imm_i),
    .src_b_kind_i(src_b_kind_i), .src_b_vec_i(src_b_vec_i), .src_b_imm_i(src_b_imm_i),
    .dst_old_i(dst_old_i), .valid_o(valid_o), .vec_o(vec_o), .vec_we_o(vec_we_o),
    .scalar_o(scalar_o), .scalar_we_o(scalar_we_o)
  );

  // register-file model: upper bits are noise, bit 0 carries the mask
  function automatic logic [DW-1:0] rf_elem(int r, int l);
    logic [DW-1:0] e;
    e = DW'(r * 32'h9E37 + l * 32'h7F4A1 + 32'h1357_9BDF);
    e[0] = rf_bits[r][l];
    return e;
  endfunction

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      mask_a_data_i[l*DW +: DW] = rf_elem(int'(mask_a_idx_o), l);
      mask_b_data_i[l*DW +: DW] = rf_elem(int'(mask_b_idx_o), l);
    end
  end

  function automatic logic [LANES-1:0] exp_mask(logic [11:0] m);
    logic [LANES-1:0] r;
    for (int l = 0; l < LANES; l++)
      r[l] = (rf_bits[m[4:0]][l] ^ m[5]) & (rf_bits[m[10:6]][l] ^ m[11]);
    return r;
  endfunction

  function automatic logic [VW-1:0] exp_dist(logic [1:0] k, logic [VW-1:0] v, logic [DW-1:0] imm);
    logic [VW-1:0] r;
    for (int l = 0; l < LANES; l++)
      r[l*DW +: DW] = (k == 2'b00) ? v[l*DW +: DW] : (k == 2'b01) ? imm : v[DW-1:0];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] v;
    for (int l = 0; l < LANES; l++) v[l*DW +: DW] = $urandom;
    return v;
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [11:0] mop,
                        input logic [1:0] ka, input logic [1:0] kb);
    logic [LANES-1:0] m;
    logic [VW-1:0] a, b, ev;
    logic [LANES-1:0] ew;
    logic fnd;
    logic [DW-1:0] fv;
    @(negedge clk);
    op_i = op; mask_op_i = mop; src_a_kind_i = ka; src_b_kind_i = kb;
    src_a_vec_i = rand_vec(); src_b_vec_i = rand_vec(); dst_old_i = rand_vec();
    src_a_imm_i = $urandom; src_b_imm_i = $urandom;
    valid_i = 1'b1;
    #1;
    chk(mask_a_idx_o == mop[4:0] && mask_b_idx_o == mop[10:6], "R1",
        VW'({mask_b_idx_o, mask_a_idx_o}), VW'({mop[10:6], mop[4:0]}));
    m = exp_mask(mop);
    a = exp_dist(ka, src_a_vec_i, src_a_imm_i);
    b = exp_dist(kb, src_b_vec_i, src_b_imm_i);
    fnd = 1'b0; fv = '0;
    for (int l = 0; l < LANES; l++) begin
      ev[l*DW +: DW] = (op == 2'b00) ? (m[l] ? a[l*DW +: DW] : dst_old_i[l*DW +: DW])
                                     : (m[l] ? b[l*DW +: DW] : a[l*DW +: DW]);
      if (m[l] && !fnd) begin fnd = 1'b1; fv = a[l*DW +: DW]; end
    end
    ew = (op == 2'b00) ? m : (op == 2'b01) ? '1 : '0;
    @(negedge clk);
    valid_i = 1'b0;
    chk(valid_o == 1'b1, "R8", VW'(valid_o), VW'(1));
    chk(vec_we_o == ew, (op == 2'b11) ? "R10" : "R2/R3/R4", VW'(vec_we_o), VW'(ew));
    if (op == 2'b00 || op == 2'b01)
      chk(vec_o == ev, (op == 2'b00) ? "R3/R7" : "R4/R7", vec_o, ev);
    if (op == 2'b10) begin
      if (fnd) exp_scalar = fv;
      chk(scalar_we_o == fnd, fnd ? "R5" : "R6", VW'(scalar_we_o), VW'(fnd));
      chk(scalar_o == exp_scalar, fnd ? "R5/R7" : "R6", VW'(scalar_o), VW'(exp_scalar));
    end else begin
      chk(scalar_we_o == 1'b0, (op == 2'b11) ? "R10" : "R5", VW'(scalar_we_o), VW'(0));
      chk(scalar_o == exp_scalar, "R6", VW'(scalar_o), VW'(exp_scalar));
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(SEED));
    for (int r = 0; r < 32; r++) rf_bits[r] = $urandom;
    rf_bits[0] = '0;
    rf_bits[1] = 32'h8000_0000;
    rf_bits[2] = '1;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(valid_o == 0 && vec_o == '0 && vec_we_o == '0 && scalar_o == '0 && scalar_we_o == 0,
        "R9", vec_o, '0);
    rst_ni = 1'b1;
    // directed: all-ones mask via both inverted on zero register
    run_op(2'b00, {1'b1, 5'd0, 1'b1, 5'd0}, 2'b00, 2'b00);  // R3 all lanes
    run_op(2'b01, {1'b1, 5'd0, 1'b1, 5'd0}, 2'b01, 2'b10);  // R4 R7
    run_op(2'b10, {1'b0, 5'd1, 1'b1, 5'd0}, 2'b00, 2'b00);  // R5 lane 31 only
    run_op(2'b10, {1'b0, 5'd7, 1'b1, 5'd7}, 2'b00, 2'b00);  // R6 empty mask
    run_op(2'b10, {1'b0, 5'd0, 1'b0, 5'd2}, 2'b01, 2'b00);  // R6 zero register
    run_op(2'b00, {1'b0, 5'd2, 1'b0, 5'd0}, 2'b00, 2'b00);  // R3 no lane written
    run_op(2'b11, {1'b1, 5'd0, 1'b1, 5'd0}, 2'b00, 2'b00);  // R10
    run_op(2'b10, {1'b1, 5'd0, 1'b0, 5'd2}, 2'b11, 2'b00);  // R5 R7 element 0
    // R8 idle cycle: no write enables
    @(negedge clk);
    chk(valid_o == 0 && vec_we_o == '0 && scalar_we_o == 0, "R8", VW'(vec_we_o), '0);
    for (int i = 0; i < 400; i++)
      run_op(2'($urandom), 12'($urandom), 2'($urandom), 2'($urandom));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule